// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port as a processor sees it. The processor writes bytes into a one-entry holding register. That register sits in front of a shift register, which sends each character on a single line that idles high. Because there are two stages, the processor can queue a second byte while the first is still being sent.

Two status flags report progress. The empty flag shows that the holding register can take a byte. The done flag shows that the line has gone quiet with nothing left to send. Each flag drives its own interrupt request, gated by its own enable. The done flag is cleared by a write-one strobe or by an interrupt acknowledge pulse.

Each bit lasts a fixed number of clock cycles, set by a divider parameter. A frame has a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits.

Top module: `uart_tx_buffer`

## Requirements
- R1: A write strobe is accepted only while the empty flag is high. A write made while the flag is low leaves the queued byte and the line unchanged.
- R2: When the transmitter is enabled, the shifter is idle and a byte is queued, the line goes low for the start bit in the cycle after the queued byte is seen.
- R3: After reset the line is high, the empty flag is 1 and the done flag is 0.
- R4: The empty request equals the empty flag AND its enable. The done request equals the done flag AND its enable.
- R5: The done flag clears in the cycle after a pulse on the write-one clear input or on the acknowledge input.
- R6: The character size code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. Written bits above the selected size are not sent.
- R7: If the enable falls during a frame, that frame finishes in full. While the enable is low, a queued byte is not started and the line stays high.
- R8: The empty flag falls in the cycle after an accepted write. It rises again in the same cycle that the start bit of that byte appears.
- R9: A frame is a low start bit, then the data bits least significant first, then the parity bit when parity is on, then one stop bit (or two when the two-stop input is set). Every bit lasts BAUD_DIV cycles. With the odd select low, the parity bit makes the count of ones over data and parity even. With the odd select high, that count is odd.
- R10: The done flag is set only when the last stop bit ends and no byte is queued. If a set and a clear fall in the same cycle, the set wins.
- R11: A write accepted in the same cycle that the last stop bit ends stops the done flag from being set. That byte's start bit begins one cycle later.
- R12: If a byte is already queued when the last stop bit ends, its start bit follows with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Transmitter enable |
| charSize | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| twoStop | input | 1 | Send two stop bits |
| dataWe | input | 1 | Write strobe for the holding register |
| dataIn | input | DATA_W | Byte to write |
| doneClr | input | 1 | Write-one clear of the done flag |
| doneAck | input | 1 | Interrupt acknowledge for the done flag |
| emptyIntEn | input | 1 | Enable for the empty request |
| doneIntEn | input | 1 | Enable for the done request |
| txLine | output | 1 | Serial output, idles high |
| emptyFlag | output | 1 | Holding register can accept a byte |
| doneFlag | output | 1 | Frame finished with nothing queued |
| emptyIrq | output | 1 | Empty interrupt request |
| doneIrq | output | 1 | Done interrupt request |

## Verification
The end of a frame's last stop bit can fall in the same cycle as either a clear of the done flag or a new write. The bench counts the bits of a frame to find the clock edge on which that stop bit ends, and drives the clear or the write in exactly that cycle. When the clear collides, the done flag must read 1 afterwards. When the write collides, the done flag must stay 0, and the line must stay high for one cycle before the new start bit.

// File: rtl/utxb_pkg.sv
package utxb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2
  } txState_t;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic capture;     // take dataIn into holding register
    logic load;        // move holding register into shifter, drive start bit
    logic shiftOut;    // present next data bit
    logic sendParity;  // present parity bit
    logic sendStop;    // drive line high
  } txStrobes_t;

  // size code 0..3 -> 5..8 data bits
  function automatic logic [3:0] charBits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/utxb_ctrl.sv
module utxb_ctrl
  import utxb_pkg::*;
#(
  parameter int BAUD_DIV = 4,
  parameter int DATA_W   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic [1:0] charSize,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic       dataWe,
  input  logic       doneClr,
  input  logic       doneAck,
  output txStrobes_t strb,
  output logic       bufFull,
  output logic       doneFlag
);

  localparam int BAUD_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(BAUD_DIV - 1);

  txState_t          state;
  logic [BAUD_W-1:0] baudCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  lastBit;
  logic              frmParity;
  logic              frmTwoStop;

  logic bitTick, acceptWr, frameEnd, startNew, setDone, lastData;

  always_comb begin
    bitTick  = (state != ST_IDLE) && (baudCnt == BAUD_LAST);
    acceptWr = dataWe && !bufFull;
    lastData = (state == ST_DATA) && (bitCnt == lastBit);
    frameEnd = bitTick && (((state == ST_STOP1) && !frmTwoStop) || (state == ST_STOP2));
    startNew = bufFull && txEnable && ((state == ST_IDLE) || frameEnd);
    setDone  = frameEnd && !bufFull && !acceptWr;

    strb.capture    = acceptWr;
    strb.load       = startNew;
    strb.shiftOut   = bitTick && ((state == ST_START) || ((state == ST_DATA) && !lastData));
    strb.sendParity = bitTick && lastData && frmParity;
    strb.sendStop   = bitTick && ((lastData && !frmParity) || (state == ST_PARITY));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      baudCnt    <= '0;
      bitCnt     <= '0;
      lastBit    <= '0;
      frmParity  <= 1'b0;
      frmTwoStop <= 1'b0;
    end else if (startNew) begin
      state      <= ST_START;
      baudCnt    <= '0;
      bitCnt     <= '0;
      lastBit    <= CNT_W'(charBits(charSize) - 4'd1);
      frmParity  <= parityEn;
      frmTwoStop <= twoStop;
    end else if (state != ST_IDLE) begin
      if (bitTick) begin
        baudCnt <= '0;
        unique case (state)
          ST_START:  state <= ST_DATA;
          ST_DATA: begin
            if (lastData) state <= frmParity ? ST_PARITY : ST_STOP1;
            else          bitCnt <= bitCnt + 1'b1;
          end
          ST_PARITY: state <= ST_STOP1;
          ST_STOP1:  state <= frmTwoStop ? ST_STOP2 : ST_IDLE;
          default:   state <= ST_IDLE;
        endcase
      end else begin
        baudCnt <= baudCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         bufFull <= 1'b0;
    else if (acceptWr) bufFull <= 1'b1;
    else if (startNew) bufFull <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   doneFlag <= 1'b0;
    else if (setDone)            doneFlag <= 1'b1;
    else if (doneClr || doneAck) doneFlag <= 1'b0;
  end

  // R1: a write while full leaves the queue occupied
  p_write_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && bufFull && !startNew) |=> bufFull);

  // R8: the transfer frees the holding register
  p_empty_on_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !bufFull);

  // R7: nothing starts while disabled
  p_no_start_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> !strb.load);

  // R10: done only rises with an idle shifter and empty queue
  p_done_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> (!bufFull && state == ST_IDLE));

  // R5: clear without a coincident set empties the flag
  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((doneClr || doneAck) && !(frameEnd && !bufFull && !dataWe)) |=> !doneFlag);

endmodule

// File: rtl/utxb_datapath.sv
module utxb_datapath
  import utxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        charSize,
  input  logic              parityOdd,
  output logic              txLine
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] charMask;
  logic [DATA_W-1:0] maskedByte;
  logic              parityBit;

  // keep only the bits inside the selected character size
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign charMask[i] = (i < int'(charBits(charSize)));
  end

  assign maskedByte = holdReg & charMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdReg <= '0;
    else if (strb.capture) holdReg <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
      txLine    <= 1'b1;
    end else if (strb.load) begin
      shiftReg  <= maskedByte;
      parityBit <= (^maskedByte) ^ parityOdd;
      txLine    <= 1'b0;
    end else if (strb.shiftOut) begin
      txLine   <= shiftReg[0];
      shiftReg <= shiftReg >> 1;
    end else if (strb.sendParity) begin
      txLine <= parityBit;
    end else if (strb.sendStop) begin
      txLine <= 1'b1;
    end
  end

  // R2: a transfer puts the start bit on the line
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !txLine);

  // R9: stop strobe drives the line high
  p_stop_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.sendStop |=> txLine);

endmodule

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer
  import utxb_pkg::*;
#(
  parameter int BAUD_DIV = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [1:0]        charSize,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              doneClr,
  input  logic              doneAck,
  input  logic              emptyIntEn,
  input  logic              doneIntEn,
  output logic              txLine,
  output logic              emptyFlag,
  output logic              doneFlag,
  output logic              emptyIrq,
  output logic              doneIrq
);

  txStrobes_t strb;
  logic       bufFull;

  utxb_ctrl #(.BAUD_DIV(BAUD_DIV), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .charSize(charSize),
    .parityEn(parityEn), .twoStop(twoStop), .dataWe(dataWe),
    .doneClr(doneClr), .doneAck(doneAck), .strb(strb),
    .bufFull(bufFull), .doneFlag(doneFlag)
  );

  utxb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .charSize(charSize), .parityOdd(parityOdd), .txLine(txLine)
  );

  assign emptyFlag = !bufFull;
  assign emptyIrq  = emptyFlag && emptyIntEn;
  assign doneIrq   = doneFlag && doneIntEn;

  // R4: requests never assert without their enable
  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (emptyIrq || doneIrq) |-> (emptyIntEn || doneIntEn));

endmodule

// File: tb/uart_tx_buffer_tb.sv
module uart_tx_buffer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BAUD       = 4;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [7:0] data;
    logic [1:0] size;
    logic       par;
    logic       odd;
    logic       two;
    logic [7:0] expData;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
    '{8'h3C, 2'd3, 1'b1, 1'b0, 1'b1, 8'h3C},
    '{8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, 8'h1F},
    '{8'hD6, 2'd1, 1'b1, 1'b0, 1'b0, 8'h16},
    '{8'h81, 2'd2, 1'b0, 1'b0, 1'b1, 8'h01},
    '{8'h6B, 2'd2, 1'b1, 1'b1, 1'b1, 8'h6B}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b1;
  logic [1:0] charSize = 2'd3;
  logic       parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic       dataWe = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       doneClr = 1'b0, doneAck = 1'b0;
  logic       emptyIntEn = 1'b0, doneIntEn = 1'b0;
  logic       txLine, emptyFlag, doneFlag, emptyIrq, doneIrq;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  uart_tx_buffer #(.BAUD_DIV(BAUD), .DATA_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .charSize(charSize),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .dataWe(dataWe), .dataIn(dataIn), .doneClr(doneClr), .doneAck(doneAck),
    .emptyIntEn(emptyIntEn), .doneIntEn(doneIntEn), .txLine(txLine),
    .emptyFlag(emptyFlag), .doneFlag(doneFlag), .emptyIrq(emptyIrq),
    .doneIrq(doneIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      nChecks++; nFail++;
      $display("FAIL watchdog (all R): actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // call at a negedge; returns at the negedge after the capturing edge
  task automatic writeByte(input logic [7:0] d);
    dataWe = 1'b1; dataIn = d;
    @(negedge clk);
    dataWe = 1'b0;
  endtask

  function automatic int frameLen(input logic [1:0] size, input logic par, input logic two);
    return 1 + 5 + int'(size) + int'(par) + 1 + int'(two);
  endfunction

  // waits for a start bit, samples every bit once per BAUD cycles, compares to R9 framing
  task automatic captureFrame(input logic [7:0] expData, input logic [1:0] size,
                              input logic par, input logic odd, input logic two,
                              input string req);
    logic [11:0] gotBits, expBits;
    int nb, nd, waitCnt;
    nd = 5 + int'(size);
    nb = frameLen(size, par, two);
    expBits = '0; gotBits = '0;
    expBits[0] = 1'b0;
    for (int i = 0; i < nd; i++) expBits[1+i] = expData[i];
    if (par) expBits[1+nd] = (^expData) ^ odd;
    for (int i = 1 + nd + int'(par); i < nb; i++) expBits[i] = 1'b1;
    waitCnt = 0;
    while (txLine !== 1'b0 && waitCnt < 200) begin
      @(negedge clk); waitCnt++;
    end
    for (int k = 0; k < nb; k++) begin
      if (k > 0) repeat (BAUD) @(negedge clk);
      gotBits[k] = txLine;
    end
    repeat (BAUD) @(negedge clk);
    check(gotBits == expBits, req, "frame bits", int'(gotBits), int'(expBits));
  endtask

  initial begin
    // R3 reset state
    repeat (3) @(negedge clk);
    check(txLine == 1'b1, "R3", "txLine after reset", txLine, 1);
    check(emptyFlag == 1'b1, "R3", "emptyFlag after reset", emptyFlag, 1);
    check(doneFlag == 1'b0, "R3", "doneFlag after reset", doneFlag, 0);
    check(emptyIrq == 1'b0, "R4", "emptyIrq with enable low", emptyIrq, 0);
    rstN = 1'b1;
    @(negedge clk);
    emptyIntEn = 1'b1; doneIntEn = 1'b1;
    #1;
    check(emptyIrq == 1'b1, "R4", "emptyIrq with enable high", emptyIrq, 1);

    // table of frames: R6 sizes and masking, R9 framing and parity, R10 done
    for (int v = 0; v < NVEC; v++) begin
      charSize = VECS[v].size; parityEn = VECS[v].par;
      parityOdd = VECS[v].odd; twoStop = VECS[v].two;
      @(negedge clk);
      writeByte(VECS[v].data);
      captureFrame(VECS[v].expData, VECS[v].size, VECS[v].par, VECS[v].odd,
                   VECS[v].two, "R6/R9");
      check(doneFlag == 1'b1, "R10", "done after lone frame", doneFlag, 1);
      check(doneIrq == 1'b1, "R4", "doneIrq follows flag", doneIrq, 1);
      if (v % 2 == 0) doneClr = 1'b1; else doneAck = 1'b1;
      @(negedge clk);
      doneClr = 1'b0; doneAck = 1'b0;
      check(doneFlag == 1'b0, "R5", "done after clear/ack", doneFlag, 0);
    end

    // R1, R8, R2, R12: double buffering and ignored writes
    charSize = 2'd3; parityEn = 1'b0; twoStop = 1'b0;
    @(negedge clk);
    dataWe = 1'b1; dataIn = 8'h11;
    @(negedge clk);
    check(emptyFlag == 1'b0, "R8", "empty falls after write", emptyFlag, 0);
    dataIn = 8'h22;
    @(negedge clk);
    check(emptyFlag == 1'b1, "R8", "empty rises with start", emptyFlag, 1);
    check(txLine == 1'b0, "R2", "start bit after transfer", txLine, 0);
    dataIn = 8'h33;
    @(negedge clk);
    dataIn = 8'h44;
    @(negedge clk);
    dataWe = 1'b0;
    check(emptyFlag == 1'b0, "R1", "queue held after ignored write", emptyFlag, 0);
    captureFrame(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, "R1");
    check(doneFlag == 1'b0, "R10", "no done while byte queued", doneFlag, 0);
    check(txLine == 1'b0, "R12", "back-to-back start", txLine, 0);
    captureFrame(8'h33, 2'd3, 1'b0, 1'b0, 1'b0, "R1");
    check(doneFlag == 1'b1, "R10", "done after queue drained", doneFlag, 1);
    doneAck = 1'b1;
    @(negedge clk);
    doneAck = 1'b0;
    check(doneFlag == 1'b0, "R5", "ack clears done", doneFlag, 0);

    // R10: clear lands in the cycle the last stop bit ends, set wins
    writeByte(8'h5C);
    repeat (10 * BAUD) @(negedge clk);
    check(doneFlag == 1'b0, "R10", "done low before frame end", doneFlag, 0);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    check(doneFlag == 1'b1, "R10", "set wins over clear", doneFlag, 1);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;

    // R11: write lands in the cycle the last stop bit ends
    writeByte(8'h55);
    repeat (10 * BAUD) @(negedge clk);
    dataWe = 1'b1; dataIn = 8'h66;
    @(negedge clk);
    dataWe = 1'b0;
    check(doneFlag == 1'b0, "R11", "done suppressed by write", doneFlag, 0);
    check(emptyFlag == 1'b0, "R11", "collision write accepted", emptyFlag, 0);
    check(txLine == 1'b1, "R11", "line idle one cycle", txLine, 1);
    @(negedge clk);
    check(txLine == 1'b0, "R11", "start one cycle after", txLine, 0);
    captureFrame(8'h66, 2'd3, 1'b0, 1'b0, 1'b0, "R11");
    check(doneFlag == 1'b1, "R10", "done after collision frame", doneFlag, 1);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;

    // R7: disable mid-frame, frame completes; queued byte waits
    writeByte(8'h5A);
    fork
      captureFrame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, "R7");
      begin repeat (8) @(negedge clk); txEnable = 1'b0; end
    join
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    writeByte(8'h77);
    begin
      int lows = 0;
      for (int c = 0; c < 12 * BAUD; c++) begin
        @(negedge clk);
        if (txLine == 1'b0) lows++;
      end
      check(lows == 0, "R7", "line idle while disabled", lows, 0);
    end
    check(emptyFlag == 1'b0, "R7", "byte held while disabled", emptyFlag, 0);
    txEnable = 1'b1;
    captureFrame(8'h77, 2'd3, 1'b0, 1'b0, 1'b0, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule